// File: doc/BRIEF.md
# Event Counter Bank with Global Start/Stop and Overflow Status

This block holds a bank of event counters. Each counter picks one of several one-bit event inputs, and it advances by one in every cycle where that event is high and the counter is enabled. Three global registers act on the whole bank. The control register starts or stops every counter on one clock edge. The overflow status register gathers one flag per counter. The clear register is how software acknowledges those flags.

Software arms a counter by loading it with the two's-complement negative of the sampling period, so the top bit stays 1 while the counter runs. When the counter wraps from all-ones to zero, its status flag is set. The interrupt request line then stays high until software clears the flag by writing a 1 to the matching bit of the clear register. A plain synchronous port gives access to every register. Reads return data one cycle after the request.

Top module: `evt_counter_bank`

## Requirements
- R1: After a synchronous active-low reset, every count, every configuration word, the global control register, the status register and the read data are zero, and `irq` is low.
- R2: Counter i advances by exactly one on a clock edge only if all three of these are 1 on that edge: its configuration enable (bit 0 of its config word), bit i of the global control register, and the event input chosen by its select field (config bits starting at bit 2). Otherwise it holds its value.
- R3: A single write to the global control register (word address 0) starts or stops all counters on the same edge. Counters with the same event that are started and stopped together therefore hold equal counts.
- R4: When an advancing counter holds all-ones, it wraps to zero and bit i of the status register (word address 1) is set. Status bits are set by nothing else.
- R5: The status register is read-only. A write to address 1 leaves it unchanged.
- R6: A write to the clear register (word address 2) clears each status bit i whose data bit i is 1. Bits written as 0, and data bits at or above the number of counters, have no effect.
- R7: If a counter overflows in the same cycle that its status bit is cleared, the bit stays set.
- R8: `irq` is a level signal. It is high exactly when some status bit is set whose counter has interrupt enable (config bit 1) set.
- R9: Overflow does not stop the counter and does not mask the interrupt. The counter keeps counting from zero, and `irq` stays high until the status bit is cleared.
- R10: A write to a counter's count word loads the counter. In a cycle where the counter would also advance, the written value wins.
- R11: Config words sit at word address 4+2i and count words at 5+2i. Config words read back enable, interrupt enable and select in their written positions. The clear register, address 3 and addresses beyond the last counter read as zero. `rd_data` updates on the edge that samples `rd_en` and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_in | input | NUM_EVT | Raw one-bit event inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address for read and write |
| wdata | input | CTR_W | Write data (register width equals counter width) |
| rd_data | output | CTR_W | Registered read data |
| irq | output | 1 | Level overflow interrupt request |

## Verification
The bench builds the block with four counters of 8 bits and four event inputs. At that width a wrap takes only a few event cycles from a preloaded value, so overflow, flags set and cleared in the same cycle, and continued counting after a wrap are all reached in a short run. With four counters, the upper half of an 8-bit clear word lies above the implemented flags, which exercises the rule that those bits are ignored. The reference model advances every counter, flag and read register alongside the design and compares `rd_data` and `irq` on every clock.

// File: rtl/ecb_pkg.sv
// Package: shared register addresses and config field positions for the
// event counter bank. Assumes word addressing, one register per address.
package ecb_pkg;
    localparam int unsigned ECB_ADDR_GCTL = 0;   // global start/stop
    localparam int unsigned ECB_ADDR_STAT = 1;   // overflow flags, read-only
    localparam int unsigned ECB_ADDR_CLR  = 2;   // write-1-to-clear flags
    localparam int unsigned ECB_ADDR_BASE = 4;   // first per-counter word

    localparam int unsigned CFG_EN_BIT  = 0;
    localparam int unsigned CFG_IE_BIT  = 1;
    localparam int unsigned CFG_SEL_LSB = 2;

    typedef enum logic [1:0] {
        GSEL_NONE = 2'd0,
        GSEL_CTL  = 2'd1,
        GSEL_STAT = 2'd2,
        GSEL_CLR  = 2'd3
    } gsel_e;
endpackage

// File: rtl/ecb_counter.sv
// Module: one counter slice. It holds the configuration (enable, interrupt
// enable, event select) and the count, advances on the selected event when
// both the local and the global enables are set, and flags a wrap from
// all-ones. Assumes the write strobes are already decoded by the parent.
module ecb_counter
    import ecb_pkg::*;
#(
    parameter int CTR_W   = 48,
    parameter int NUM_EVT = 16,
    localparam int SEL_W  = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] ev_in,
    input  logic               gbl_en,
    input  logic               cfg_we,
    input  logic               cnt_we,
    input  logic [CTR_W-1:0]   wdata,
    output logic               en_o,
    output logic               ie_o,
    output logic [SEL_W-1:0]   sel_o,
    output logic [CTR_W-1:0]   cnt_o,
    output logic               ovf_o
);
    logic               en_q;
    logic               ie_q;
    logic [SEL_W-1:0]   sel_q;
    logic [CTR_W-1:0]   cnt_q;
    logic               ev_hit;
    logic               advance;

    // Pick the selected event; out-of-range selects never fire.
    always_comb begin
        ev_hit = 1'b0;
        if (int'(sel_q) < NUM_EVT) ev_hit = ev_in[sel_q];
    end

    assign advance = en_q & gbl_en & ev_hit;
    assign ovf_o   = advance & (&cnt_q);

    // Configuration word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            ie_q  <= 1'b0;
            sel_q <= '0;
        end else if (cfg_we) begin
            en_q  <= wdata[CFG_EN_BIT];
            ie_q  <= wdata[CFG_IE_BIT];
            sel_q <= wdata[CFG_SEL_LSB +: SEL_W];
        end
    end

    // Count register: a software load beats an increment in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_we)  cnt_q <= wdata;
        else if (advance) cnt_q <= cnt_q + 1'b1;
    end

    assign en_o  = en_q;
    assign ie_o  = ie_q;
    assign sel_o = sel_q;
    assign cnt_o = cnt_q;
endmodule

// File: rtl/ecb_status.sv
// Module: overflow flag register and interrupt request. Flags are set by
// counter wrap pulses and cleared only through the write-1-to-clear strobe;
// a wrap in the clearing cycle wins. Assumes clr_bits only covers real counters.
module ecb_status #(
    parameter int NUM_CTR = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTR-1:0] ovf,
    input  logic               clr_we,
    input  logic [NUM_CTR-1:0] clr_bits,
    input  logic [NUM_CTR-1:0] ie,
    output logic [NUM_CTR-1:0] status_o,
    output logic               irq_o
);
    logic [NUM_CTR-1:0] stat_q;
    logic [NUM_CTR-1:0] clr_mask;

    assign clr_mask = clr_we ? clr_bits : '0;

    // Flag update: clear first, then OR in new wraps so they survive.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | ovf;
    end

    assign status_o = stat_q;
    assign irq_o    = |(stat_q & ie);
endmodule

// File: rtl/evt_counter_bank.sv
// Module: top of the event counter bank. It decodes the register port,
// holds the global control register, instantiates one slice per counter
// and the status block, and registers read data. Assumes that the word
// address space covers ECB_ADDR_BASE + 2*NUM_CTR words and that
// CTR_W >= NUM_CTR and CTR_W >= CFG_SEL_LSB + select width.
module evt_counter_bank
    import ecb_pkg::*;
#(
    parameter int NUM_CTR = 6,
    parameter int CTR_W   = 48,
    parameter int NUM_EVT = 16,
    parameter int ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] ev_in,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CTR_W-1:0]   wdata,
    output logic [CTR_W-1:0]   rd_data,
    output logic               irq
);
    localparam int SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    gsel_e                    gsel;
    logic [NUM_CTR-1:0]       gctl_q;
    logic [NUM_CTR-1:0]       cfg_we;
    logic [NUM_CTR-1:0]       cnt_we;
    logic [NUM_CTR-1:0]       en_vec;
    logic [NUM_CTR-1:0]       ie_vec;
    logic [NUM_CTR-1:0]       ovf_vec;
    logic [NUM_CTR-1:0]       stat_vec;
    logic [NUM_CTR*CTR_W-1:0] cnt_flat;
    logic [CTR_W-1:0]         cfg_word [NUM_CTR];
    logic [CTR_W-1:0]         rd_next;
    logic [CTR_W-1:0]         rd_q;

    // Decode of the three global addresses.
    always_comb begin
        gsel = GSEL_NONE;
        if (addr == ADDR_W'(ECB_ADDR_GCTL)) gsel = GSEL_CTL;
        if (addr == ADDR_W'(ECB_ADDR_STAT)) gsel = GSEL_STAT;
        if (addr == ADDR_W'(ECB_ADDR_CLR))  gsel = GSEL_CLR;
    end

    // Global control: one write moves every enable bit on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                          gctl_q <= '0;
        else if (wr_en && gsel == GSEL_CTL)  gctl_q <= wdata[NUM_CTR-1:0];
    end

    for (genvar gi = 0; gi < NUM_CTR; gi++) begin : g_ctr
        localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(ECB_ADDR_BASE + 2 * gi);
        localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(ECB_ADDR_BASE + 2 * gi + 1);
        logic [SEL_W-1:0] sel_w;

        assign cfg_we[gi] = wr_en && (addr == CFG_A);
        assign cnt_we[gi] = wr_en && (addr == CNT_A);

        ecb_counter #(
            .CTR_W   (CTR_W),
            .NUM_EVT (NUM_EVT)
        ) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .ev_in  (ev_in),
            .gbl_en (gctl_q[gi]),
            .cfg_we (cfg_we[gi]),
            .cnt_we (cnt_we[gi]),
            .wdata  (wdata),
            .en_o   (en_vec[gi]),
            .ie_o   (ie_vec[gi]),
            .sel_o  (sel_w),
            .cnt_o  (cnt_flat[gi*CTR_W +: CTR_W]),
            .ovf_o  (ovf_vec[gi])
        );

        assign cfg_word[gi] = CTR_W'({sel_w, ie_vec[gi], en_vec[gi]});
    end

    ecb_status #(
        .NUM_CTR (NUM_CTR)
    ) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf      (ovf_vec),
        .clr_we   (wr_en && gsel == GSEL_CLR),
        .clr_bits (wdata[NUM_CTR-1:0]),
        .ie       (ie_vec),
        .status_o (stat_vec),
        .irq_o    (irq)
    );

    // Read mux: globals, then per-counter words; clear and holes read zero.
    always_comb begin
        rd_next = '0;
        case (gsel)
            GSEL_CTL:  rd_next = CTR_W'(gctl_q);
            GSEL_STAT: rd_next = CTR_W'(stat_vec);
            default:   rd_next = '0;
        endcase
        for (int i = 0; i < NUM_CTR; i++) begin
            if (addr == ADDR_W'(ECB_ADDR_BASE + 2 * i))     rd_next = cfg_word[i];
            if (addr == ADDR_W'(ECB_ADDR_BASE + 2 * i + 1)) rd_next = cnt_flat[i*CTR_W +: CTR_W];
        end
    end

    // Read data register: loads only when a read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= rd_next;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/ecb_checker.sv
// Module: assertion checker for the event counter bank, bound to the top.
// It watches the port strobes, the wrap pulses, the flag register, the
// global enables and the counts. Assumes reset is held for at least two clocks.
module ecb_checker
    import ecb_pkg::*;
#(
    parameter int NUM_CTR = 6,
    parameter int CTR_W   = 48,
    parameter int ADDR_W  = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        addr,
    input logic [NUM_CTR-1:0]       clr_data,
    input logic [NUM_CTR-1:0]       ovf,
    input logic [NUM_CTR-1:0]       status,
    input logic [NUM_CTR-1:0]       gctl,
    input logic [NUM_CTR-1:0]       cnt_we,
    input logic [NUM_CTR*CTR_W-1:0] cnt_flat,
    input logic                     irq
);
    logic clr_hit;
    assign clr_hit = wr_en && (addr == ADDR_W'(ECB_ADDR_CLR));

    // A wrap always leaves its flag set on the next edge, even under a clear.
    p_ovf_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|ovf) |=> ((status & $past(ovf)) == $past(ovf)));

    // Flags only rise where a wrap was reported.
    p_rise_by_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status)) & ~$past(ovf)) == '0);

    // Flags only fall through a clear write carrying a 1 in that bit.
    p_fall_by_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(status) & ~status) != '0) |->
            ($past(clr_hit) && ((($past(status) & ~status) & ~$past(clr_data)) == '0)));

    // Interrupt needs at least one pending flag.
    p_irq_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

    for (genvar gi = 0; gi < NUM_CTR; gi++) begin : g_hold
        // A counter whose global bit was off and was not loaded keeps its value.
        p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(gctl[gi]) && !$past(cnt_we[gi])) |->
                $stable(cnt_flat[gi*CTR_W +: CTR_W]));
    end
endmodule

bind evt_counter_bank ecb_checker #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .clr_data (wdata[NUM_CTR-1:0]),
    .ovf      (ovf_vec),
    .status   (stat_vec),
    .gctl     (gctl_q),
    .cnt_we   (cnt_we),
    .cnt_flat (cnt_flat),
    .irq      (irq)
);

// File: tb/evt_counter_bank_tb.sv
`timescale 1ns/1ps
module evt_counter_bank_tb;
    localparam int N  = 4;
    localparam int CW = 8;
    localparam int NE = 4;
    localparam int AW = 5;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] ev = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [CW-1:0] wdata = '0;
    logic [CW-1:0] rd_data;
    logic          irq;

    int vectors = 0;
    int fails = 0;
    bit started = 0;
    string cur_req = "R1";

    // Reference model state
    int m_cnt [N];
    int m_en  [N];
    int m_ie  [N];
    int m_sel [N];
    int m_gctl = 0;
    int m_stat = 0;
    int m_rd = 0;

    always #2 clk = ~clk;

    evt_counter_bank #(.NUM_CTR(N), .CTR_W(CW), .NUM_EVT(NE), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_in(ev), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rd_data(rd_data), .irq(irq)
    );

    function automatic int model_read(int a);
        int k;
        if (a == 0) return m_gctl;
        if (a == 1) return m_stat;
        if (a >= 4 && a < 4 + 2 * N) begin
            k = (a - 4) / 2;
            if (a % 2 == 1) return m_cnt[k];
            return m_en[k] | (m_ie[k] << 1) | (m_sel[k] << 2);
        end
        return 0;
    endfunction

    function automatic bit model_irq();
        for (int i = 0; i < N; i++)
            if (((m_stat >> i) & 1) == 1 && m_ie[i] == 1) return 1'b1;
        return 1'b0;
    endfunction

    // Model update on each rising edge from the inputs held since the falling edge
    always @(posedge clk) begin
        int nrd;
        int ovf;
        int clr;
        bit adv;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_cnt[i] = 0; m_en[i] = 0; m_ie[i] = 0; m_sel[i] = 0;
            end
            m_gctl = 0; m_stat = 0; m_rd = 0;
        end else begin
            nrd = m_rd;
            if (rd_en) nrd = model_read(int'(addr));
            ovf = 0;
            for (int i = 0; i < N; i++) begin
                adv = (m_en[i] == 1) && (((m_gctl >> i) & 1) == 1) && (ev[m_sel[i]] == 1'b1);
                if (adv && m_cnt[i] == MAXV) ovf = ovf | (1 << i);
                if (wr_en && int'(addr) == 5 + 2 * i) m_cnt[i] = int'(wdata);
                else if (adv) m_cnt[i] = (m_cnt[i] + 1) & MAXV;
                if (wr_en && int'(addr) == 4 + 2 * i) begin
                    m_en[i]  = int'(wdata[0]);
                    m_ie[i]  = int'(wdata[1]);
                    m_sel[i] = int'(wdata[3:2]);
                end
            end
            if (wr_en && addr == 0) m_gctl = int'(wdata) & ((1 << N) - 1);
            clr = (wr_en && addr == 2) ? (int'(wdata) & ((1 << N) - 1)) : 0;
            m_stat = (m_stat & ~clr) | ovf;
            m_rd = nrd;
        end
    end

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            vectors++;
            if (int'(rd_data) != m_rd) begin
                fails++;
                $display("FAIL %s rd_data actual=%0h expected=%0h", cur_req, rd_data, m_rd);
            end
            vectors++;
            if (irq !== model_irq()) begin
                fails++;
                $display("FAIL %s irq actual=%0b expected=%0b", cur_req, irq, model_irq());
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_get(input int a, output int v);
        @(negedge clk);
        rd_en = 1'b1; addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        v = int'(rd_data);
    endtask

    task automatic chk_rd(input int a, input int exp, input string req);
        int v;
        rd_get(a, v);
        vectors++;
        if (v != exp) begin
            fails++;
            $display("FAIL %s read addr %0d actual=%0h expected=%0h", req, a, v, exp);
        end
    endtask

    task automatic chk_irq(input bit exp, input string req);
        @(negedge clk);
        vectors++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s irq actual=%0b expected=%0b", req, irq, exp);
        end
    endtask

    task automatic pulse(input int bitn, input int cycles);
        @(negedge clk);
        ev[bitn] = 1'b1;
        repeat (cycles) @(negedge clk);
        ev[bitn] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int a;
        int b;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        started = 1;

        // R1: reset state
        cur_req = "R1";
        chk_rd(0, 0, "R1");
        chk_rd(1, 0, "R1");
        chk_rd(5, 0, "R1");
        chk_irq(1'b0, "R1");

        // R11: configuration words read back in place
        cur_req = "R11";
        wr(4, 3);          // ctr0: enable, irq enable, event 0
        wr(6, 1);          // ctr1: enable, event 0
        wr(8, 1 | (1 << 2)); // ctr2: enable, event 1
        chk_rd(4, 3, "R11");
        chk_rd(8, 5, "R11");

        // R2: no counting while the global bit is off
        cur_req = "R2";
        pulse(0, 3);
        chk_rd(5, 0, "R2");
        chk_rd(7, 0, "R2");

        // R3: shared start and stop give equal counts
        cur_req = "R3";
        @(negedge clk); ev[0] = 1'b1;
        wr(0, 3);
        repeat (6) @(negedge clk);
        wr(0, 0);
        ev[0] = 1'b0;
        rd_get(5, a);
        rd_get(7, b);
        vectors++;
        if (a != b || a == 0) begin
            fails++;
            $display("FAIL R3 counts actual=%0d expected=%0d (nonzero)", b, a);
        end
        chk_rd(0, 0, "R3");

        // R2: exact increments and event selection
        cur_req = "R2";
        wr(5, 0); wr(7, 0); wr(0, 7);
        @(negedge clk); ev[0] = 1'b1; ev[1] = 1'b1;
        repeat (2) @(negedge clk); ev[1] = 1'b0;
        repeat (3) @(negedge clk); ev[0] = 1'b0;
        chk_rd(5, 5, "R2");
        chk_rd(7, 5, "R2");
        chk_rd(9, 2, "R2");

        // R4: wrap to zero sets the flag; R8 raises the interrupt
        cur_req = "R4";
        wr(0, 0); wr(5, 8'hFE); wr(0, 1);
        pulse(0, 2);
        chk_rd(5, 0, "R4");
        chk_rd(1, 1, "R4");
        chk_irq(1'b1, "R8");

        // R9: counting continues and the interrupt stays up
        cur_req = "R9";
        pulse(0, 3);
        chk_rd(5, 3, "R9");
        chk_irq(1'b1, "R9");

        // R5: status register ignores writes
        cur_req = "R5";
        wr(1, 0);
        chk_rd(1, 1, "R5");

        // R6: write-1-to-clear, zeros and high bits ignored
        cur_req = "R6";
        wr(2, 0);
        chk_rd(1, 1, "R6");
        wr(2, 8'hF0);
        chk_rd(1, 1, "R6");
        wr(2, 1);
        chk_rd(1, 0, "R6");
        chk_irq(1'b0, "R6");

        // R7: wrap in the clearing cycle keeps the flag
        cur_req = "R7";
        wr(5, 8'hFF);
        pulse(0, 1);
        chk_rd(1, 1, "R7");
        wr(5, 8'hFF);
        @(negedge clk);
        ev[0] = 1'b1; wr_en = 1'b1; addr = AW'(2); wdata = CW'(1);
        @(negedge clk);
        ev[0] = 1'b0; wr_en = 1'b0;
        chk_rd(1, 1, "R7");
        chk_rd(5, 0, "R7");

        // R8: flag without interrupt enable leaves irq low
        cur_req = "R8";
        wr(2, 15);
        chk_irq(1'b0, "R8");
        wr(0, 2); wr(7, 8'hFF);
        pulse(0, 1);
        chk_rd(1, 2, "R8");
        chk_irq(1'b0, "R8");
        wr(6, 3);
        chk_irq(1'b1, "R8");
        wr(2, 2);
        chk_irq(1'b0, "R8");

        // R10: a load beats a same-cycle increment
        cur_req = "R10";
        wr(0, 1);
        @(negedge clk); ev[0] = 1'b1;
        wr(5, 8'h40);
        ev[0] = 1'b0;
        chk_rd(5, 8'h40, "R10");

        // R11: clear register and holes read zero
        cur_req = "R11";
        wr(0, 0);
        chk_rd(2, 0, "R11");
        wr(3, 8'h55);
        chk_rd(3, 0, "R11");
        chk_rd(12, 0, "R11");
        chk_rd(6, 3, "R11");

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule